// File: doc/BRIEF.md
# DMA Write Cache-Line Splitter

This block takes one inbound memory-write request and cuts it into writes for a banked cache. A request gives a start address, a length in 32-bit dwords, a 4-bit enable for the first dword, a 4-bit enable for the final dword and a tag. The payload then arrives one dword at a time on a valid/ready stream. Each cache write leaves on a valid/ready output. It is either a whole 64-byte line with an all-zero byte mask, or an 8-byte partial write with an 8-bit byte mask. Every write carries the tag, a last flag, a bank number and an address that can be hashed.

At each point where the current address is line aligned, the block picks a full-line write when enough payload remains. Otherwise it packs dwords in pairs into 8-byte partial writes. Three configuration pins are held steady for the length of a request. `hash_en` folds upper address bits into the index bits. `pbank_en` and `pbank_vec` fold the 8 bank numbers onto fewer banks when only some banks are present.

Back-pressure rules:
- A request is taken only while `req_ready` is high, and `req_ready` is high only when the block is idle.
- A payload dword moves on a cycle where `pay_valid` and `pay_ready` are both high.
- `pay_ready` stays low while a cache write is waiting, so no dword is lost to a stall.
- A raised `wr_valid` keeps every `wr_*` field steady until `wr_ready` takes the write.
- `done` pulses for one cycle, in the cycle after the final write of a request is taken.

Top module: `dwsplit`

## Requirements
- R1: If the start address is not on a 64-byte line and the length is larger than the dwords left in that line (16 minus address bits [5:2]), those leading dwords leave as partial writes. Processing then continues from the next line start.
- R2: At a line-aligned current address, a full-line write (`wr_full`=1) is chosen when more than 16 dwords remain, or when exactly 16 remain and the last enable is 4'b1111. Otherwise every remaining dword leaves in partial writes (`wr_full`=0).
- R3: A full-line write has `wr_mask`=0, `wr_last`=1 and an address with bits [5:0] zero. Dword i of the line (i = 0..15, in arrival order) sits in `wr_data[511-32*i -: 32]`.
- R4: A partial write has an address with bits [2:0] zero. A dword whose address bit 2 is 0 sits in `wr_data[63:32]` with mask bits [7:4]. A dword whose address bit 2 is 1 sits in `wr_data[31:0]` with mask bits [3:0]. Absent lanes and all other data bits are zero.
- R5: The first dword of the request uses the first enable and the final dword uses the last enable; a one-dword request uses the first enable. All other dwords use 4'b1111. Each enable is bit-reversed into its mask nibble, so enable bit 0 becomes the nibble's top bit.
- R6: A partial write is emitted after a dword whose address bit 2 is 1, or after the final dword. Its `wr_last` is 1 when it holds the final dword or when the address bits [5:2] of its last dword are 4'b1111.
- R7: A one-dword request with first enable 4'b0000 consumes its dword and produces no write. A zero-length request consumes nothing and produces no write. Both still pulse `done`.
- R8: `wr_bank` is address bits [8:6]. With `pbank_en`=1, `pbank_vec` rewrites the bank: 0001 sets bits [2:1] to 00, 0010 to 01, 0100 to 10 and 1000 to 11; 0011 clears bit 2; 1111 leaves it unchanged. Any other vector leaves the bank unchanged and raises `wr_bank_err`.
- R9: With `hash_en`=1 and address bit 39 at 0, output address bits [17:13] are addr[32:28]^addr[17:13] and bits [12:11] are addr[19:18]^addr[12:11]. All other bits, and all bits when hashing is off or bit 39 is 1, pass through.
- R10: A request is accepted only when idle. A stalled write holds all fields. No payload is taken while a write is pending. Exactly the request's length in dwords is consumed. `done` pulses one cycle after the final write is accepted (or after the final dword, or after acceptance, in the R7 cases).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hash_en | input | 1 | Enable address index hashing |
| pbank_en | input | 1 | Enable partial-bank remapping |
| pbank_vec | input | 4 | Present-bank vector for remapping |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Block idle, request taken |
| req_addr | input | 64 | Start byte address |
| req_len | input | LEN_W (11) | Length in dwords |
| req_first_be | input | 4 | Enables of the first dword |
| req_last_be | input | 4 | Enables of the final dword |
| req_tag | input | TAG_W (8) | Request tag |
| pay_valid | input | 1 | Payload dword offered |
| pay_ready | output | 1 | Payload dword taken |
| pay_data | input | 32 | Payload dword |
| wr_valid | output | 1 | Cache write offered |
| wr_ready | input | 1 | Cache write taken |
| wr_addr | output | 64 | Write address, hashed |
| wr_bank | output | 3 | Target bank |
| wr_bank_err | output | 1 | Illegal present-bank vector |
| wr_full | output | 1 | 1 = full line, 0 = 8-byte partial |
| wr_mask | output | 8 | Byte mask of partial writes, zero for lines |
| wr_data | output | 512 | Line data or partial data in [63:0] |
| wr_tag | output | TAG_W (8) | Request tag |
| wr_last | output | 1 | Last flag |
| done | output | 1 | One-cycle pulse at request end |

## Verification
A wrong remaining-dword count or a misplaced address shows up at once as a wrong choice between line and partial. It also changes the packing of the next write, so the error reaches the port at the first write after the fault. A bad gather-lane index or a stale buffer shows in `wr_data` on that same write. An error in the first/last tracking shows in the mask nibble of the first or final write. A broken stall path either changes fields while `wr_valid` waits, or lets too many payload dwords through before `done` pulses. The sweep runs every start offset within a line against every length up to a little over two lines, under random stalls on both streams.

// File: rtl/dwsplit_pkg.sv
package dwsplit_pkg;
  localparam int ADDR_W  = 64;
  localparam int DW_W    = 32;
  localparam int LINE_DW = 16;
  localparam int LINE_W  = DW_W * LINE_DW;
  localparam int SLOT_W  = $clog2(LINE_DW);
  localparam int BANK_W  = 3;
  localparam int MASK_W  = 8;

  typedef enum logic [1:0] {ST_IDLE, ST_GATHER, ST_SEND} split_st_t;

  function automatic logic [3:0] rev4(input logic [3:0] e);
    return {e[0], e[1], e[2], e[3]};
  endfunction

  // line write is chosen only at a line start with enough payload left
  function automatic logic line_ok(input logic [SLOT_W-1:0] pos,
                                   input logic [31:0] left,
                                   input logic [3:0] lbe);
    return (pos == '0) &&
           ((left > 32'(LINE_DW)) || ((left == 32'(LINE_DW)) && (&lbe)));
  endfunction
endpackage

// File: rtl/dwsplit_addr_map.sv
module dwsplit_addr_map
  import dwsplit_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_in,
  input  logic              hash_en,
  input  logic              pbank_en,
  input  logic [3:0]        pbank_vec,
  output logic [ADDR_W-1:0] addr_out,
  output logic [BANK_W-1:0] bank,
  output logic              bank_err
);
  logic [ADDR_W-1:0] h;
  logic [BANK_W-1:0] b;

  always_comb begin
    h = addr_in;
    if (hash_en && !addr_in[39]) begin
      h[17:13] = addr_in[32:28] ^ addr_in[17:13];
      h[12:11] = addr_in[19:18] ^ addr_in[12:11];
    end
  end

  always_comb begin
    b        = h[8:6];
    bank_err = 1'b0;
    if (pbank_en) begin
      unique case (pbank_vec)
        4'b0001: b[2:1] = 2'b00;
        4'b0010: b[2:1] = 2'b01;
        4'b0100: b[2:1] = 2'b10;
        4'b1000: b[2:1] = 2'b11;
        4'b0011: b[2]   = 1'b0;
        4'b1111: ;
        default: bank_err = 1'b1;
      endcase
    end
  end

  assign addr_out = h;
  assign bank     = b;
endmodule

// File: rtl/dwsplit_gather.sv
module dwsplit_gather #(
  parameter int LANES = 16,
  parameter int DW    = 32
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  clr,
  input  logic                  we,
  input  logic [$clog2(LANES)-1:0] idx,
  input  logic [DW-1:0]         din,
  output logic [LANES*DW-1:0]   line
);
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    logic [DW-1:0] lane_q;
    always_ff @(posedge clk) begin
      if (!rst_n || clr)                 lane_q <= '0;
      else if (we && (idx == k[$clog2(LANES)-1:0])) lane_q <= din;
    end
    assign line[k*DW +: DW] = lane_q;
  end
endmodule

// File: rtl/dwsplit.sv
module dwsplit
  import dwsplit_pkg::*;
#(
  parameter int LEN_W = 11,
  parameter int TAG_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              hash_en,
  input  logic              pbank_en,
  input  logic [3:0]        pbank_vec,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [LEN_W-1:0]  req_len,
  input  logic [3:0]        req_first_be,
  input  logic [3:0]        req_last_be,
  input  logic [TAG_W-1:0]  req_tag,
  input  logic              pay_valid,
  output logic              pay_ready,
  input  logic [DW_W-1:0]   pay_data,
  output logic              wr_valid,
  input  logic              wr_ready,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [BANK_W-1:0] wr_bank,
  output logic              wr_bank_err,
  output logic              wr_full,
  output logic [MASK_W-1:0] wr_mask,
  output logic [LINE_W-1:0] wr_data,
  output logic [TAG_W-1:0]  wr_tag,
  output logic              wr_last,
  output logic              done
);
  split_st_t         st;
  logic [ADDR_W-1:0] cur_addr, txn_addr;
  logic [LEN_W-1:0]  rem;
  logic [3:0]        fbe_q, lbe_q;
  logic [TAG_W-1:0]  tag_q;
  logic [MASK_W-1:0] mask_q;
  logic              first_q, full_q, skip_q, last_q, done_q;

  logic              pay_fire, wr_fire, req_fire, is_final, line_end, emit, buf_clr;
  logic [3:0]        nib;
  logic [SLOT_W-1:0] gidx;
  logic [ADDR_W-1:0] base_addr;

  assign req_ready = (st == ST_IDLE);
  assign pay_ready = (st == ST_GATHER);
  assign wr_valid  = (st == ST_SEND);
  assign req_fire  = req_valid && req_ready;
  assign pay_fire  = pay_valid && pay_ready;
  assign wr_fire   = wr_valid && wr_ready;

  assign is_final  = (rem == LEN_W'(1));
  assign line_end  = &cur_addr[5:2];
  assign nib       = rev4(first_q ? fbe_q : (is_final ? lbe_q : 4'hF));
  assign emit      = full_q ? line_end : (cur_addr[2] || is_final);
  assign gidx      = full_q ? ~cur_addr[5:2] : {{(SLOT_W-1){1'b0}}, ~cur_addr[2]};
  assign buf_clr   = req_fire || wr_fire;

  dwsplit_gather #(.LANES(LINE_DW), .DW(DW_W)) u_gather (
    .clk  (clk),
    .rst_n(rst_n),
    .clr  (buf_clr),
    .we   (pay_fire),
    .idx  (gidx),
    .din  (pay_data),
    .line (wr_data)
  );

  assign base_addr = full_q ? {txn_addr[ADDR_W-1:6], 6'b0} : {txn_addr[ADDR_W-1:3], 3'b0};

  dwsplit_addr_map u_map (
    .addr_in  (base_addr),
    .hash_en  (hash_en),
    .pbank_en (pbank_en),
    .pbank_vec(pbank_vec),
    .addr_out (wr_addr),
    .bank     (wr_bank),
    .bank_err (wr_bank_err)
  );

  assign wr_full = full_q;
  assign wr_mask = full_q ? '0 : mask_q;
  assign wr_tag  = tag_q;
  assign wr_last = last_q;
  assign done    = done_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st       <= ST_IDLE;
      cur_addr <= '0;
      txn_addr <= '0;
      rem      <= '0;
      fbe_q    <= '0;
      lbe_q    <= '0;
      tag_q    <= '0;
      mask_q   <= '0;
      first_q  <= 1'b0;
      full_q   <= 1'b0;
      skip_q   <= 1'b0;
      last_q   <= 1'b0;
      done_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      unique case (st)
        ST_IDLE: if (req_fire) begin
          cur_addr <= {req_addr[ADDR_W-1:2], 2'b00};
          txn_addr <= {req_addr[ADDR_W-1:2], 2'b00};
          rem      <= req_len;
          fbe_q    <= req_first_be;
          lbe_q    <= req_last_be;
          tag_q    <= req_tag;
          mask_q   <= '0;
          first_q  <= 1'b1;
          skip_q   <= (req_len == LEN_W'(1)) && (req_first_be == 4'b0);
          full_q   <= line_ok(req_addr[5:2], 32'(req_len), req_last_be);
          if (req_len == '0) done_q <= 1'b1;
          else               st     <= ST_GATHER;
        end
        ST_GATHER: if (pay_fire) begin
          cur_addr <= cur_addr + ADDR_W'(4);
          rem      <= rem - LEN_W'(1);
          first_q  <= 1'b0;
          if (!full_q) begin
            if (cur_addr[2]) mask_q[3:0] <= nib;
            else             mask_q[7:4] <= nib;
          end
          if (emit) begin
            last_q <= full_q || is_final || line_end;
            if (skip_q) begin
              st     <= ST_IDLE;
              done_q <= 1'b1;
            end else begin
              st <= ST_SEND;
            end
          end
        end
        ST_SEND: if (wr_fire) begin
          if (rem == '0) begin
            st     <= ST_IDLE;
            done_q <= 1'b1;
          end else begin
            st       <= ST_GATHER;
            txn_addr <= cur_addr;
            mask_q   <= '0;
            full_q   <= line_ok(cur_addr[5:2], 32'(rem), lbe_q);
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dwsplit_chk.sv
module dwsplit_chk
  import dwsplit_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              pbank_en,
  input logic              req_valid,
  input logic              req_ready,
  input logic              pay_valid,
  input logic              pay_ready,
  input logic              wr_valid,
  input logic              wr_ready,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              wr_bank_err,
  input logic              wr_full,
  input logic [MASK_W-1:0] wr_mask,
  input logic [LINE_W-1:0] wr_data,
  input logic [TAG_W-1:0]  wr_tag,
  input logic              wr_last,
  input logic              done
);
  // R10
  wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data) &&
                                 $stable(wr_mask) && $stable(wr_last) && $stable(wr_tag)));

  // R10
  no_pay_while_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(pay_ready && wr_valid));

  // R10
  idle_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> !wr_valid && !pay_ready);

  // R10
  done_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(wr_valid && wr_ready) || $past(req_valid && req_ready) ||
                     $past(pay_valid && pay_ready)));

  // R3
  line_form_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && wr_full) |-> (wr_last && wr_mask == '0 && wr_addr[5:0] == 6'b0));

  // R4
  part_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_full) |-> (wr_addr[2:0] == 3'b0 && wr_data[LINE_W-1:64] == '0));

  // R8
  bank_err_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_bank_err |-> pbank_en);
endmodule

bind dwsplit dwsplit_chk #(.TAG_W(TAG_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .pbank_en   (pbank_en),
  .req_valid  (req_valid),
  .req_ready  (req_ready),
  .pay_valid  (pay_valid),
  .pay_ready  (pay_ready),
  .wr_valid   (wr_valid),
  .wr_ready   (wr_ready),
  .wr_addr    (wr_addr),
  .wr_bank_err(wr_bank_err),
  .wr_full    (wr_full),
  .wr_mask    (wr_mask),
  .wr_data    (wr_data),
  .wr_tag     (wr_tag),
  .wr_last    (wr_last),
  .done       (done)
);

// File: tb/sim_dwsplit.sv
module sim_dwsplit;
  localparam int CLK_T = 10;
  localparam int LEN_W = 11;
  localparam int TAG_W = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic hash_en = 1'b0, pbank_en = 1'b0;
  logic [3:0] pbank_vec = 4'hF;
  logic req_valid = 1'b0;
  logic req_ready;
  logic [63:0] req_addr = '0;
  logic [LEN_W-1:0] req_len = '0;
  logic [3:0] req_first_be = '0, req_last_be = '0;
  logic [TAG_W-1:0] req_tag = '0;
  logic pay_valid = 1'b0;
  logic pay_ready;
  logic [31:0] pay_data = '0;
  logic wr_valid;
  logic wr_ready = 1'b0;
  logic [63:0] wr_addr;
  logic [2:0] wr_bank;
  logic wr_bank_err, wr_full, wr_last, done;
  logic [7:0] wr_mask;
  logic [511:0] wr_data;
  logic [TAG_W-1:0] wr_tag;

  always #(CLK_T/2) clk = ~clk;

  dwsplit #(.LEN_W(LEN_W), .TAG_W(TAG_W)) u0 (
    .clk(clk), .rst_n(rst_n), .hash_en(hash_en), .pbank_en(pbank_en), .pbank_vec(pbank_vec),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_len(req_len),
    .req_first_be(req_first_be), .req_last_be(req_last_be), .req_tag(req_tag),
    .pay_valid(pay_valid), .pay_ready(pay_ready), .pay_data(pay_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_bank(wr_bank),
    .wr_bank_err(wr_bank_err), .wr_full(wr_full), .wr_mask(wr_mask), .wr_data(wr_data),
    .wr_tag(wr_tag), .wr_last(wr_last), .done(done)
  );

  typedef struct {
    logic [63:0]  addr;
    logic [2:0]   bank;
    logic         err;
    logic         full;
    logic [7:0]   mask;
    logic [511:0] data;
    logic         last;
  } exp_t;

  exp_t exp_q[$];
  int total = 0, bad = 0, cycles = 0;
  bit hung = 0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic check(input bit ok, input string rq, input logic [511:0] act, input logic [511:0] expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", rq, act, expv);
    end
  endtask

  function automatic logic [31:0] pw(input int cnt, input int j);
    return {8'(cnt * 7), 8'(j), 16'(cnt) ^ 16'h5A3C};
  endfunction

  function automatic logic [63:0] m_hash(input logic [63:0] a, input bit en);
    logic [63:0] r = a;
    if (en && a[39] == 1'b0) begin
      r[17:13] = a[17:13] ^ a[32:28];
      r[12:11] = a[12:11] ^ a[19:18];
    end
    return r;
  endfunction

  task automatic m_bank(input logic [63:0] a, input bit pe, input logic [3:0] v,
                        output logic [2:0] b, output logic e);
    b = a[8:6];
    e = 1'b0;
    if (pe) begin
      case (v)
        4'b0001: b = {2'b00, a[6]};
        4'b0010: b = {2'b01, a[6]};
        4'b0100: b = {2'b10, a[6]};
        4'b1000: b = {2'b11, a[6]};
        4'b0011: b = {1'b0, a[7:6]};
        4'b1111: b = a[8:6];
        default: e = 1'b1;
      endcase
    end
  endtask

  task automatic build_exp(input int cnt, input logic [63:0] addr, input int len,
                           input logic [3:0] fbe, input logic [3:0] lbe,
                           input bit he, input bit pe, input logic [3:0] pv);
    logic [63:0] a = {addr[63:2], 2'b00};
    int left = len;
    int j = 0;
    exp_t t;
    if (len == 0 || (len == 1 && fbe == 4'b0)) return;
    while (left > 0) begin
      t.data = '0;
      t.mask = '0;
      if (a[5:2] == 4'd0 && (left > 16 || (left == 16 && lbe == 4'hF))) begin
        t.full = 1'b1;
        t.last = 1'b1;
        t.addr = a;
        for (int i = 0; i < 16; i++) t.data[511-32*i -: 32] = pw(cnt, j + i);
        a = a + 64; left -= 16; j += 16;
      end else begin
        logic [63:0] ta = a;
        bit stop = 0;
        t.full = 1'b0;
        while (!stop) begin
          logic [3:0] e = (j == 0) ? fbe : ((left == 1) ? lbe : 4'hF);
          logic [3:0] n = {e[0], e[1], e[2], e[3]};
          if (a[2]) begin t.mask[3:0] = n; t.data[31:0]  = pw(cnt, j); end
          else      begin t.mask[7:4] = n; t.data[63:32] = pw(cnt, j); end
          t.last = (left == 1) || (a[5:2] == 4'hF);
          stop = a[2] || (left == 1);
          a = a + 4; left--; j++;
        end
        t.addr = {ta[63:3], 3'b000};
      end
      t.addr = m_hash(t.addr, he);
      m_bank(t.addr, pe, pv, t.bank, t.err);
      exp_q.push_back(t);
    end
  endtask

  task automatic run_req(input int cnt, input logic [63:0] addr, input int len,
                         input logic [3:0] fbe, input logic [3:0] lbe,
                         input bit he, input bit pe, input logic [3:0] pv, input bit full_off);
    int pidx = 0;
    int lc = 0;
    bit acc = 0, fin = 0, held = 0;
    exp_t h;
    logic [7:0] tg = 8'(cnt * 3 + 1);
    exp_q.delete();
    build_exp(cnt, addr, len, fbe, lbe, he, pe, pv);
    hash_en = he; pbank_en = pe; pbank_vec = pv;
    req_addr = addr; req_len = LEN_W'(len); req_first_be = fbe; req_last_be = lbe; req_tag = tg;
    while (!fin) begin
      @(negedge clk);
      cycles++; lc++;
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (held) begin
        check(wr_valid && wr_addr == h.addr && wr_data == h.data && wr_mask == h.mask &&
              wr_last == h.last, "R10 stall hold", {wr_valid, wr_addr}, {1'b1, h.addr});
        held = 0;
      end
      if (done) begin
        fin = 1;
        check(exp_q.size() == 0, "R7 write count", 512'(exp_q.size()), 0);
        check(pidx == len, "R10 dwords consumed", 512'(pidx), 512'(len));
        req_valid = 1'b0; pay_valid = 1'b0; wr_ready = 1'b0;
        break;
      end
      if (acc) check(!req_ready, "R10 busy not ready", 512'(req_ready), 0);
      if (pay_ready && pidx >= len) check(1'b0, "R10 extra payload", 512'(pidx), 512'(len));
      req_valid = !acc;
      wr_ready  = lfsr[0] | lfsr[3];
      pay_valid = (lfsr[5] | lfsr[9]) && (pidx < len);
      pay_data  = pw(cnt, pidx);
      if (req_valid && req_ready) acc = 1;
      if (pay_valid && pay_ready) pidx++;
      if (wr_valid && !wr_ready) begin
        held = 1;
        h.addr = wr_addr; h.data = wr_data; h.mask = wr_mask; h.last = wr_last;
      end
      if (wr_valid && wr_ready) begin
        if (exp_q.size() == 0) begin
          check(1'b0, "R7 unexpected write", wr_addr, 0);
        end else begin
          exp_t t = exp_q.pop_front();
          check(wr_full == t.full, full_off ? "R1 line choice" : "R2 line choice", wr_full, t.full);
          check(wr_addr == t.addr, "R9 address", wr_addr, t.addr);
          check(wr_data == t.data, t.full ? "R3 line data" : "R4 partial data", wr_data, t.data);
          check(wr_mask == t.mask, "R5 mask", wr_mask, t.mask);
          check(wr_last == t.last, "R6 last flag", wr_last, t.last);
          check(wr_bank == t.bank && wr_bank_err == t.err, "R8 bank", {wr_bank_err, wr_bank}, {t.err, t.bank});
          check(wr_tag == tg, "R10 tag", wr_tag, tg);
        end
      end
      if (lc > 4000 || cycles > 190000) begin
        check(1'b0, "R10 watchdog", 512'(lc), 0);
        hung = 1;
        fin = 1;
      end
    end
  endtask

  initial begin
    logic [3:0] be_set [4] = '{4'hF, 4'h0, 4'h6, 4'h8};
    logic [3:0] pv_set [8] = '{4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011, 4'b1111, 4'b0101, 4'b0000};
    int cnt = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(req_ready && !wr_valid && !pay_ready && !done, "R10 reset state",
          {req_ready, wr_valid, pay_ready, done}, 4'b1000);
    for (int off = 0; off < 18 && !hung; off++) begin
      for (int len = 0; len < 37 && !hung; len++) begin
        logic [63:0] base = cnt[2] ? 64'h0000_00A5_5A5A_4000 : 64'h0000_0012_3456_7000;
        logic [63:0] a = ((base + 64'(cnt) * 64'h0000_0001_1000_1840) & ~64'h3F) + 64'(off * 4);
        logic [3:0] fbe = be_set[(off * 3 + len + cnt / 4) % 4];
        logic [3:0] lbe = be_set[(off + len + cnt) % 4];
        if (len == 16 && off == 0) lbe = cnt[0] ? 4'hF : 4'h7;
        run_req(cnt, a, len, fbe, lbe, cnt[1], cnt[3], pv_set[cnt % 8],
                (a[5:0] != 6'd0));
        cnt++;
      end
    end
    // R7: single dword with zero first enables, then with non-zero enables
    if (!hung) run_req(cnt, 64'h0000_0000_0000_1004, 1, 4'h0, 4'hF, 1'b0, 1'b0, 4'hF, 1'b1);
    if (!hung) run_req(cnt + 1, 64'h0000_0000_0000_1004, 1, 4'h3, 4'h0, 1'b0, 1'b0, 4'hF, 1'b1);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule